// File: doc/BRIEF.md
# Multi-mode effective address generator

This block turns a decoded load request into a final memory address. A request carries a 3-bit mode code, an access size, a base register number, an index register number and a 16-bit immediate. The block reads an external general-purpose register file through two combinational read ports: port A always shows the base register and port B the index register. Six address forms are supported: absolute, register-indirect, base plus signed offset, base plus index, memory-indirect, and base with post-increment or post-decrement.

Most modes deliver the address one cycle after the request is accepted. Memory-indirect mode instead issues a read of the word at the base register's value. It holds that read until the memory acknowledges it, then delivers the returned word as the final address. The two auto modes also return the updated base through a write-back port, in the same cycle as the address. While a memory-indirect read is outstanding, the block raises `busy` and ignores new requests.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `wb_en`, `mem_req` and `busy` are all low.
- R2: Mode code 0 (absolute) delivers the zero-extended immediate on `addr_out`, with `addr_valid` high in the cycle after acceptance.
- R3: Mode code 1 (register-indirect) delivers the base register's value one cycle after acceptance.
- R4: Mode code 2 (displaced) delivers the base register's value plus the sign-extended immediate, modulo 2^32, one cycle after acceptance.
- R5: Mode code 3 (indexed) delivers the sum of the base and index register values, modulo 2^32, one cycle after acceptance.
- R6: Mode code 4 (memory-indirect) behaves as follows:
  - In the cycle after acceptance, `mem_req` is high and `mem_addr` holds the base register's value.
  - Both are held until a cycle with `mem_ack` high.
  - In the next cycle, `addr_valid` is high and `addr_out` equals the `mem_rdata` that was sampled with the acknowledge.
- R7: Mode code 5 (post-increment) delivers the unmodified base value. In the same cycle as `addr_valid`, it raises `wb_en`, with `wb_idx` equal to the base register number and `wb_data` equal to base plus the step. The step is 1 for size code 0, 2 for size code 1, and 4 for size codes 2 and 3.
- R8: Mode code 6 (post-decrement) delivers the unmodified base value. In the same cycle as `addr_valid`, it writes back base minus the step defined in R7, modulo 2^32.
- R9: `busy` is high from the cycle after a memory-indirect request is accepted through the cycle of `mem_ack`. A request presented while `busy` is high produces no address and no write-back.
- R10: Mode code 7 is reserved. A request with it produces no `addr_valid`, no `mem_req` and no `wb_en`, and leaves `busy` low.
- R11: `addr_valid` and `wb_en` are single-cycle pulses for each accepted request. `wb_en` is raised only for modes 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_mode | input | 3 | Addressing mode code (0..7) |
| req_size | input | 2 | Access size code, which sets the auto-mode step |
| req_base | input | 3 | Base register number |
| req_index | input | 3 | Index register number |
| req_imm | input | 16 | Immediate or signed offset |
| busy | output | 1 | Memory-indirect read outstanding |
| rf_ra_idx | output | 3 | Register file read port A index |
| rf_ra_data | input | 32 | Register file read port A data |
| rf_rb_idx | output | 3 | Register file read port B index |
| rf_rb_data | input | 32 | Register file read port B data |
| mem_req | output | 1 | Indirect memory read request |
| mem_addr | output | 32 | Indirect memory read address |
| mem_ack | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| addr_valid | output | 1 | Final address strobe |
| addr_out | output | 32 | Final address |
| wb_en | output | 1 | Base register write-back enable |
| wb_idx | output | 3 | Write-back register number |
| wb_data | output | 32 | Updated base value |

## Verification
A corrupted wait state would show up at once as a delivered address with no acknowledge, or as a `busy` signal that never clears, within the cycle after the fault. A wrong mode decode or a wrong step shows up as a mismatched `addr_out` or `wb_data` on the very next strobe. The register file in the bench takes its writes from the write-back port, so a bad write-back also skews later addresses that use that register. Requests presented while `busy` is high, and requests with the reserved code, are checked for stray strobes during and after the wait.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [2:0] {
        EA_ABS  = 3'd0,
        EA_REG  = 3'd1,
        EA_DISP = 3'd2,
        EA_IDX  = 3'd3,
        EA_MIND = 3'd4,
        EA_PINC = 3'd5,
        EA_PDEC = 3'd6,
        EA_RSVD = 3'd7
    } ea_mode_e;
endpackage

// File: rtl/ea_step.sv
module ea_step #(
    parameter int AW = 32
) (
    input  logic [1:0]    size,
    output logic [AW-1:0] step
);
    always_comb begin
        case (size)
            2'd0:    step = AW'(1);
            2'd1:    step = AW'(2);
            default: step = AW'(4);
        endcase
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 16
) (
    input  logic [2:0]      mode,
    input  logic [1:0]      size,
    input  logic [AW-1:0]   base_v,
    input  logic [AW-1:0]   idx_v,
    input  logic [OFFW-1:0] imm,
    output logic [AW-1:0]   addr,
    output logic [AW-1:0]   wb_val,
    output logic            is_auto,
    output logic            is_mind,
    output logic            is_bad
);
    localparam int EXTW = AW - OFFW;

    logic [AW-1:0] step;
    logic [AW-1:0] imm_z;
    logic [AW-1:0] imm_s;
    ea_mode_e      m;

    ea_step #(.AW(AW)) u_step (.size(size), .step(step));

    assign imm_z = {{EXTW{1'b0}}, imm};
    assign imm_s = {{EXTW{imm[OFFW-1]}}, imm};
    assign m     = ea_mode_e'(mode);

    always_comb begin
        addr    = base_v;
        wb_val  = base_v;
        is_auto = 1'b0;
        is_mind = 1'b0;
        is_bad  = 1'b0;
        case (m)
            EA_ABS:  addr = imm_z;
            EA_REG:  addr = base_v;
            EA_DISP: addr = base_v + imm_s;
            EA_IDX:  addr = base_v + idx_v;
            EA_MIND: is_mind = 1'b1;
            EA_PINC: begin
                is_auto = 1'b1;
                wb_val  = base_v + step;
            end
            EA_PDEC: begin
                is_auto = 1'b1;
                wb_val  = base_v - step;
            end
            default: is_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
    parameter int AW   = 32,
    parameter int OFFW = 16,
    parameter int NREG = 8,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_mode,
    input  logic [1:0]      req_size,
    input  logic [RIDX-1:0] req_base,
    input  logic [RIDX-1:0] req_index,
    input  logic [OFFW-1:0] req_imm,
    output logic            busy,
    output logic [RIDX-1:0] rf_ra_idx,
    input  logic [AW-1:0]   rf_ra_data,
    output logic [RIDX-1:0] rf_rb_idx,
    input  logic [AW-1:0]   rf_rb_data,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [AW-1:0]   mem_rdata,
    output logic            addr_valid,
    output logic [AW-1:0]   addr_out,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_idx,
    output logic [AW-1:0]   wb_data
);
    typedef struct packed {
        logic            waiting;
        logic            mreq;
        logic [AW-1:0]   maddr;
        logic            av;
        logic [AW-1:0]   aout;
        logic            wb;
        logic [RIDX-1:0] wbi;
        logic [AW-1:0]   wbd;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0] calc_addr;
    logic [AW-1:0] calc_wb;
    logic          is_auto, is_mind, is_bad;

    assign rf_ra_idx = req_base;
    assign rf_rb_idx = req_index;

    ea_calc #(.AW(AW), .OFFW(OFFW)) u_calc (
        .mode    (req_mode),
        .size    (req_size),
        .base_v  (rf_ra_data),
        .idx_v   (rf_rb_data),
        .imm     (req_imm),
        .addr    (calc_addr),
        .wb_val  (calc_wb),
        .is_auto (is_auto),
        .is_mind (is_mind),
        .is_bad  (is_bad)
    );

    always_comb begin
        st_d    = st_q;
        st_d.av = 1'b0;
        st_d.wb = 1'b0;
        if (st_q.waiting) begin
            if (mem_ack) begin
                st_d.waiting = 1'b0;
                st_d.mreq    = 1'b0;
                st_d.av      = 1'b1;
                st_d.aout    = mem_rdata;
            end
        end else if (req_valid && !is_bad) begin
            if (is_mind) begin
                st_d.waiting = 1'b1;
                st_d.mreq    = 1'b1;
                st_d.maddr   = rf_ra_data;
            end else begin
                st_d.av   = 1'b1;
                st_d.aout = calc_addr;
                st_d.wb   = is_auto;
                st_d.wbi  = req_base;
                st_d.wbd  = calc_wb;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.waiting;
    assign mem_req    = st_q.mreq;
    assign mem_addr   = st_q.maddr;
    assign addr_valid = st_q.av;
    assign addr_out   = st_q.aout;
    assign wb_en      = st_q.wb;
    assign wb_idx     = st_q.wbi;
    assign wb_data    = st_q.wbd;
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
    parameter int AW   = 32,
    parameter int OFFW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_mode,
    input logic [OFFW-1:0] req_imm,
    input logic            busy,
    input logic            mem_req,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_ack,
    input logic [AW-1:0]   mem_rdata,
    input logic            addr_valid,
    input logic [AW-1:0]   addr_out,
    input logic            wb_en
);
    a_r2_abs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && req_mode == 3'd0 |=>
        addr_valid && addr_out == {{(AW-OFFW){1'b0}}, $past(req_imm)});

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    a_r6_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> addr_valid && addr_out == $past(mem_rdata));

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_ack |=> busy && !addr_valid);

    a_r10_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && req_mode == 3'd7 |=> !addr_valid && !mem_req && !wb_en);

    a_r11_wb_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> addr_valid);
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.AW(AW), .OFFW(OFFW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_imm(req_imm), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .addr_valid(addr_valid),
    .addr_out(addr_out), .wb_en(wb_en)
);

// File: tb/eff_addr_gen_test.sv
`timescale 1ns/1ps
module eff_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_size = '0;
    logic [2:0]  req_base = '0;
    logic [2:0]  req_index = '0;
    logic [15:0] req_imm = '0;
    logic        busy;
    logic [2:0]  rf_ra_idx, rf_rb_idx;
    logic [31:0] rf_ra_data, rf_rb_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        addr_valid;
    logic [31:0] addr_out;
    logic        wb_en;
    logic [2:0]  wb_idx;
    logic [31:0] wb_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] gpr [8];

    always #2 clk = ~clk;

    function automatic logic [31:0] init_val(input int i);
        case (i)
            0: return 32'h0000_0000;
            7: return 32'hFFFF_FFFF;
            default: return 32'h1000_0000 + i * 32'h0123_4568;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) gpr[i] <= init_val(i);
        end else if (wb_en) begin
            gpr[wb_idx] <= wb_data;
        end
    end

    assign rf_ra_data = gpr[rf_ra_idx];
    assign rf_rb_data = gpr[rf_rb_idx];

    eff_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_size(req_size), .req_base(req_base), .req_index(req_index),
        .req_imm(req_imm), .busy(busy), .rf_ra_idx(rf_ra_idx),
        .rf_ra_data(rf_ra_data), .rf_rb_idx(rf_rb_idx), .rf_rb_data(rf_rb_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .addr_valid(addr_valid), .addr_out(addr_out),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] step_of(input logic [1:0] s);
        return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [2:0] m, input logic [31:0] bv,
                                             input logic [31:0] xv, input logic [15:0] imm);
        case (m)
            3'd0: return {16'h0000, imm};
            3'd2: return bv + {{16{imm[15]}}, imm};
            3'd3: return bv + xv;
            default: return bv;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic do_op(input logic [2:0] m, input logic [1:0] sz, input logic [2:0] b,
                         input logic [2:0] x, input logic [15:0] imm, input int dly);
        logic [31:0] bv, xv, ea, rv;
        bit auto_m;
        @(negedge clk);
        chk(!addr_valid && !wb_en, "R11 pulse", {30'd0, addr_valid, wb_en}, 32'd0);
        bv = gpr[b];
        xv = gpr[x];
        req_valid = 1'b1; req_mode = m; req_size = sz;
        req_base = b; req_index = x; req_imm = imm;
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 3'd7) begin
            chk(!addr_valid && !mem_req && !wb_en && !busy, "R10 reserved",
                {28'd0, addr_valid, mem_req, wb_en, busy}, 32'd0);
        end else if (m == 3'd4) begin
            chk(mem_req && busy && !addr_valid, "R6 request", {29'd0, mem_req, busy, addr_valid}, 32'd6);
            chk(mem_addr == bv, "R6 mem_addr", mem_addr, bv);
            for (int i = 0; i < dly; i++) begin
                req_valid = 1'b1; req_mode = 3'd0; req_imm = 16'h5A5A;
                @(negedge clk);
                chk(busy && mem_req && !addr_valid && !wb_en, "R9 busy wait",
                    {28'd0, busy, mem_req, addr_valid, wb_en}, 32'd12);
                chk(mem_addr == bv, "R6 addr held", mem_addr, bv);
            end
            rv = $urandom;
            mem_ack = 1'b1; mem_rdata = rv;
            @(negedge clk);
            mem_ack = 1'b0; req_valid = 1'b0;
            chk(addr_valid && !busy && !wb_en && !mem_req, "R6 deliver strobe",
                {28'd0, addr_valid, busy, wb_en, mem_req}, 32'd8);
            chk(addr_out == rv, "R6 deliver addr", addr_out, rv);
            if (dly > 0) begin
                @(negedge clk);
                chk(!addr_valid, "R9 ignored while busy", {31'd0, addr_valid}, 32'd0);
            end
        end else begin
            ea = exp_addr(m, bv, xv, imm);
            auto_m = (m == 3'd5) || (m == 3'd6);
            chk(addr_valid && !busy, {tag_of(m), " strobe"}, {30'd0, addr_valid, busy}, 32'd2);
            chk(addr_out == ea, {tag_of(m), " addr"}, addr_out, ea);
            chk(wb_en == auto_m, "R11 wb_en only in auto modes", {31'd0, wb_en}, {31'd0, auto_m});
            if (auto_m) begin
                chk(wb_idx == b, {tag_of(m), " wb_idx"}, {29'd0, wb_idx}, {29'd0, b});
                if (m == 3'd5)
                    chk(wb_data == bv + step_of(sz), "R7 wb_data", wb_data, bv + step_of(sz));
                else
                    chk(wb_data == bv - step_of(sz), "R8 wb_data", wb_data, bv - step_of(sz));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!addr_valid && !wb_en && !mem_req && !busy, "R1 reset",
            {28'd0, addr_valid, wb_en, mem_req, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!addr_valid && !wb_en && !mem_req && !busy, "R1 after reset",
            {28'd0, addr_valid, wb_en, mem_req, busy}, 32'd0);
        // directed corners
        do_op(3'd0, 2'd0, 3'd1, 3'd2, 16'hFFFF, 0);   // R2 zero-extend
        do_op(3'd1, 2'd0, 3'd3, 3'd0, 16'h0000, 0);   // R3
        do_op(3'd2, 2'd0, 3'd2, 3'd0, 16'hFFF0, 0);   // R4 negative offset
        do_op(3'd2, 2'd0, 3'd0, 3'd0, 16'h8000, 0);   // R4 wrap below zero
        do_op(3'd3, 2'd0, 3'd4, 3'd4, 16'h0000, 0);   // R5 same register twice
        do_op(3'd3, 2'd0, 3'd7, 3'd1, 16'h0000, 0);   // R5 wrap
        do_op(3'd5, 2'd3, 3'd7, 3'd0, 16'h0000, 0);   // R7 wrap past all-ones
        do_op(3'd6, 2'd2, 3'd0, 3'd0, 16'h0000, 0);   // R8 underflow below zero
        do_op(3'd5, 2'd0, 3'd5, 3'd0, 16'h0000, 0);   // R7 step 1
        do_op(3'd6, 2'd1, 3'd5, 3'd0, 16'h0000, 0);   // R8 step 2
        do_op(3'd4, 2'd0, 3'd6, 3'd0, 16'h0000, 0);   // R6 immediate ack
        do_op(3'd4, 2'd0, 3'd2, 3'd0, 16'h0000, 3);   // R6/R9 waits
        do_op(3'd7, 2'd0, 3'd1, 3'd1, 16'h1234, 0);   // R10
        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            do_op(3'($urandom % 8), 2'($urandom % 4), 3'($urandom % 8), 3'($urandom % 8),
                  16'($urandom), int'($urandom % 4));
        end
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule